// File: doc/BRIEF.md
# Clear-on-Read Event Status and Interrupt Unit

This unit gathers single-cycle event pulses raised by the command, data and FIFO engines of a memory-card host controller. It latches them into a 13-bit sticky status register and drives a single interrupt line. Software owns an enable mask that uses the same bit positions as the status register. The interrupt line is high whenever any latched event has its enable bit set. Software reaches the unit through a small word-addressed read/write port.

Reading the status word returns every latched event and clears it in the same cycle, so each event is reported once. A pulse that lands in the same cycle as that read is not lost: it appears in the following status value. Disabling an event in the mask only silences the interrupt. The event stays latched and raises the line as soon as its enable bit is set again. A third word reports the card busy level. That word is live and is never cleared by reading.

Status bit positions: 0 data done, 1 busy done, 2 command done, 3 data read timeout, 4 response timeout, 5 write CRC error, 6 read CRC error, 7 response CRC error, 8 reserved, 9 transmit ready, 10 receive ready, 11 card-detect data-line edge, 12 transfer done.

Top module: `evt_irq_unit`

## Requirements
- R1: After a synchronous active-high reset, the status register, the mask register, `irq_o` and `rdata_o` are all zero.
- R2: A pulse on `evt_i[n]` sets status bit n in the following cycle for n in 0..7 and 9..12. Bit 8 is reserved: it never sets and always reads 0.
- R3: A read at word address 0 presents the latched status, zero-extended, on `rdata_o` one cycle after `rd_en_i`. The same clock edge clears every bit that was returned, so an immediate second read returns 0 unless new events arrived.
- R4: An event pulse in the same cycle as a status read is kept. It is absent from that read's data and present in the next status read.
- R5: A write at word address 1 loads the mask from `wdata_i[12:0]`. A read at address 1 returns it. Bit 8 and bits 13..31 of the mask read 0.
- R6: `irq_o` is registered. It equals the OR of (status AND mask) as it stood one cycle earlier, so it falls one cycle after a read clears the last enabled event.
- R7: An event latched while its mask bit is 0 raises `irq_o` one cycle after that mask bit is written to 1.
- R8: Writing 0 to the mask drops `irq_o` one cycle later and leaves all latched status bits unchanged.
- R9: A read at word address 2 returns the `busy_i` level in bit 0, with zeros above. The read does not clear it, and repeated reads follow the live level.
- R10: Writes to addresses other than 1 change no register. Reads of address 3 return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 13 | Single-cycle event pulses, one per status bit |
| busy_i | input | 1 | Card busy level |
| rd_en_i | input | 1 | Read strobe, one cycle per read |
| wr_en_i | input | 1 | Write strobe |
| addr_i | input | 2 | Word address (0 status, 1 mask, 2 busy, 3 unused) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data, valid the cycle after the strobe |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The bound checker watches several behaviours on every cycle. It checks that each accepted pulse lands in the status register, and that a status read returns the pre-clear value and empties the register. It checks that the interrupt follows any enabled pending bit, that an empty mask forces the line low, and that busy reads report the live level. It also checks that writes to other addresses leave the mask alone. Only the bench's scenarios show the whole sequences. These are: an event raised while masked and later enabled, status surviving a mask-off, a pulse racing a clearing read and showing up one read later, and the exact cycle in which the line falls after the clearing read.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int EVT_W  = 13;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 2;
  // bit 8 is reserved and never latches
  localparam logic [EVT_W-1:0] KEEP_BITS = 13'h1EFF;
  localparam int A_STAT = 0;
  localparam int A_MASK = 1;
  localparam int A_BUSY = 2;
endpackage

// File: rtl/evt_status_reg.sv
module evt_status_reg #(
  parameter int               EVT_W = 13,
  parameter logic [EVT_W-1:0] KEEP  = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_W-1:0] set_i,
  input  logic             clr_i,
  output logic [EVT_W-1:0] status_o
);
  for (genvar i = 0; i < EVT_W; i++) begin : g_bit
    if (KEEP[i]) begin : g_live
      logic q;
      always_ff @(posedge clk) begin
        if (rst) q <= 1'b0;
        else     q <= (q & ~clr_i) | set_i[i];
      end
      assign status_o[i] = q;
    end else begin : g_hole
      assign status_o[i] = 1'b0;
    end
  end
endmodule

// File: rtl/evt_mask_reg.sv
module evt_mask_reg #(
  parameter int               EVT_W = 13,
  parameter logic [EVT_W-1:0] KEEP  = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic [EVT_W-1:0] value_i,
  output logic [EVT_W-1:0] mask_o
);
  always_ff @(posedge clk) begin
    if (rst)         mask_o <= '0;
    else if (load_i) mask_o <= value_i & KEEP;
  end
endmodule

// File: rtl/evt_read_port.sv
module evt_read_port #(
  parameter int EVT_W  = 13,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [EVT_W-1:0]  status_i,
  input  logic [EVT_W-1:0]  mask_i,
  input  logic              busy_i,
  output logic              clr_o,
  output logic [DATA_W-1:0] rdata_o
);
  import evt_irq_pkg::*;
  logic [DATA_W-1:0] mux;

  always_comb begin
    mux = '0;
    if (addr_i == ADDR_W'(A_STAT))      mux = {{(DATA_W-EVT_W){1'b0}}, status_i};
    else if (addr_i == ADDR_W'(A_MASK)) mux = {{(DATA_W-EVT_W){1'b0}}, mask_i};
    else if (addr_i == ADDR_W'(A_BUSY)) mux = {{(DATA_W-1){1'b0}}, busy_i};
  end

  assign clr_o = rd_en_i && (addr_i == ADDR_W'(A_STAT));

  always_ff @(posedge clk) begin
    if (rst)          rdata_o <= '0;
    else if (rd_en_i) rdata_o <= mux;
  end
endmodule

// File: rtl/evt_irq_drive.sv
module evt_irq_drive #(
  parameter int EVT_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [EVT_W-1:0] status_i,
  input  logic [EVT_W-1:0] mask_i,
  output logic             irq_o
);
  always_ff @(posedge clk) begin
    if (rst) irq_o <= 1'b0;
    else     irq_o <= |(status_i & mask_i);
  end
endmodule

// File: rtl/evt_irq_unit.sv
module evt_irq_unit
  import evt_irq_pkg::*;
#(
  parameter int               P_EVT_W  = EVT_W,
  parameter int               P_DATA_W = DATA_W,
  parameter int               P_ADDR_W = ADDR_W,
  parameter logic [P_EVT_W-1:0] P_KEEP = KEEP_BITS
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [P_EVT_W-1:0]  evt_i,
  input  logic                busy_i,
  input  logic                rd_en_i,
  input  logic                wr_en_i,
  input  logic [P_ADDR_W-1:0] addr_i,
  input  logic [P_DATA_W-1:0] wdata_i,
  output logic [P_DATA_W-1:0] rdata_o,
  output logic                irq_o
);
  logic [P_EVT_W-1:0] status_w;
  logic [P_EVT_W-1:0] mask_w;
  logic               clr_w;
  logic               mask_ld;
  logic               unused_wdata_hi;

  assign mask_ld         = wr_en_i && (addr_i == P_ADDR_W'(A_MASK));
  assign unused_wdata_hi = ^wdata_i[P_DATA_W-1:P_EVT_W];

  evt_status_reg #(.EVT_W(P_EVT_W), .KEEP(P_KEEP)) u_stat (
    .clk(clk), .rst(rst), .set_i(evt_i), .clr_i(clr_w), .status_o(status_w)
  );

  evt_mask_reg #(.EVT_W(P_EVT_W), .KEEP(P_KEEP)) u_mask (
    .clk(clk), .rst(rst), .load_i(mask_ld),
    .value_i(wdata_i[P_EVT_W-1:0]), .mask_o(mask_w)
  );

  evt_read_port #(.EVT_W(P_EVT_W), .DATA_W(P_DATA_W), .ADDR_W(P_ADDR_W)) u_rd (
    .clk(clk), .rst(rst), .rd_en_i(rd_en_i), .addr_i(addr_i),
    .status_i(status_w), .mask_i(mask_w), .busy_i(busy_i),
    .clr_o(clr_w), .rdata_o(rdata_o)
  );

  evt_irq_drive #(.EVT_W(P_EVT_W)) u_irq (
    .clk(clk), .rst(rst), .status_i(status_w), .mask_i(mask_w), .irq_o(irq_o)
  );
endmodule

// File: rtl/evt_irq_unit_chk.sv
module evt_irq_unit_chk #(
  parameter int               EVT_W  = 13,
  parameter int               DATA_W = 32,
  parameter int               ADDR_W = 2,
  parameter logic [EVT_W-1:0] KEEP   = '1
) (
  input logic              clk,
  input logic              rst,
  input logic [EVT_W-1:0]  evt_i,
  input logic              busy_i,
  input logic              rd_en_i,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              irq_o,
  input logic [EVT_W-1:0]  status_q,
  input logic [EVT_W-1:0]  mask_q
);
  logic rd_st, rd_bz;
  assign rd_st = rd_en_i && addr_i == ADDR_W'(0);
  assign rd_bz = rd_en_i && addr_i == ADDR_W'(2);

  AST_RST_CLEAN: assert property (@(posedge clk)
    rst |=> (status_q == '0 && mask_q == '0 && !irq_o && rdata_o == '0)); // R1
  AST_EVT_LANDS: assert property (@(posedge clk) disable iff (rst)
    (|(evt_i & KEEP)) |=> ((status_q & $past(evt_i & KEEP)) == $past(evt_i & KEEP))); // R2
  AST_RD_RETURNS: assert property (@(posedge clk) disable iff (rst)
    rd_st |=> rdata_o == {{(DATA_W-EVT_W){1'b0}}, $past(status_q)}); // R3
  AST_RD_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_st && evt_i == '0) |=> status_q == '0); // R3
  AST_RACE_KEPT: assert property (@(posedge clk) disable iff (rst)
    (rd_st && (|(evt_i & KEEP))) |=> status_q == $past(evt_i & KEEP)); // R4
  AST_HOLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    ((status_q | mask_q) & ~KEEP) == '0); // R5
  AST_IRQ_PEND: assert property (@(posedge clk) disable iff (rst)
    (|(status_q & mask_q)) |=> irq_o); // R7
  AST_MASK_OFF: assert property (@(posedge clk) disable iff (rst)
    (mask_q == '0) |=> !irq_o); // R8
  AST_BUSY_RD: assert property (@(posedge clk) disable iff (rst)
    rd_bz |=> rdata_o == {{(DATA_W-1){1'b0}}, $past(busy_i)}); // R9
  AST_WR_OTHER: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i != ADDR_W'(1)) |=> mask_q == $past(mask_q)); // R10
endmodule

bind evt_irq_unit evt_irq_unit_chk #(
  .EVT_W(P_EVT_W), .DATA_W(P_DATA_W), .ADDR_W(P_ADDR_W), .KEEP(P_KEEP)
) u_chk (
  .clk(clk), .rst(rst), .evt_i(evt_i), .busy_i(busy_i), .rd_en_i(rd_en_i),
  .wr_en_i(wr_en_i), .addr_i(addr_i), .rdata_o(rdata_o), .irq_o(irq_o),
  .status_q(status_w), .mask_q(mask_w)
);

// File: tb/evt_irq_unit_test.sv
module evt_irq_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [12:0] evt = '0;
  logic        busy = 1'b0;
  logic        rd_en = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  logic pend = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  evt_irq_unit uut (
    .clk(clk), .rst(rst), .evt_i(evt), .busy_i(busy), .rd_en_i(rd_en),
    .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  // monitor: compare read data the cycle after each strobe
  always @(posedge clk) pend <= rd_en;
  always @(negedge clk) begin
    if (pend && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      total++;
      if (rdata !== e) begin
        bad++;
        $display("FAIL %s rdata actual=%h expected=%h", t, rdata, e);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      bad++;
      total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk_irq(input logic e, input string t);
    total++;
    if (irq !== e) begin
      bad++;
      $display("FAIL %s irq actual=%b expected=%b", t, irq, e);
    end
  endtask

  task automatic rd_evt(input logic [1:0] a, input logic [12:0] e,
                        input logic [31:0] x, input string t);
    @(negedge clk);
    rd_en = 1'b1; addr = a; evt = e;
    exp_q.push_back(x); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0; evt = '0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] x, input string t);
    rd_evt(a, '0, x, t);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [12:0] b);
    @(negedge clk);
    evt = b;
    @(negedge clk);
    evt = '0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    total++;
    if (rdata !== 32'h0) begin
      bad++;
      $display("FAIL R1 rdata actual=%h expected=0", rdata);
    end
    chk_irq(1'b0, "R1");
    rd(2'd0, 32'h0, "R1 status");
    rd(2'd1, 32'h0, "R1 mask");

    // R2/R3: latch and clear
    pulse(13'h0005);
    rd(2'd0, 32'h5, "R2 R3 first read");
    rd(2'd0, 32'h0, "R3 cleared");
    pulse(13'h1FFF);
    rd(2'd0, 32'h1EFF, "R2 all bits, bit8 reserved");
    rd(2'd0, 32'h0, "R3 cleared after all");

    // R5: mask layout
    wr(2'd1, 32'hFFFF_FFFF);
    rd(2'd1, 32'h1EFF, "R5 mask holes zero");
    wr(2'd1, 32'h0);
    rd(2'd1, 32'h0, "R5 mask cleared");

    // R7/R8: pending while masked
    pulse(13'h0010);
    @(negedge clk);
    chk_irq(1'b0, "R8 masked event silent");
    wr(2'd1, 32'h10);
    chk_irq(1'b0, "R7 one-cycle lag");
    @(negedge clk);
    chk_irq(1'b1, "R7 raised after unmask");
    wr(2'd1, 32'h0);
    @(negedge clk);
    chk_irq(1'b0, "R8 mask off drops irq");
    rd(2'd0, 32'h10, "R8 status kept");

    // R6: fall timing after clearing read
    wr(2'd1, 32'h1);
    pulse(13'h0001);
    @(negedge clk);
    chk_irq(1'b1, "R6 raised");
    rd(2'd0, 32'h1, "R6 read");
    chk_irq(1'b1, "R6 still high right after clearing edge");
    @(negedge clk);
    chk_irq(1'b0, "R6 fell");

    // R4: event racing the read
    pulse(13'h0002);
    rd_evt(2'd0, 13'h0004, 32'h2, "R4 race read");
    rd(2'd0, 32'h4, "R4 kept event");
    rd(2'd0, 32'h0, "R4 then empty");

    // R9: busy level
    busy = 1'b1;
    rd(2'd2, 32'h1, "R9 busy high");
    rd(2'd2, 32'h1, "R9 not cleared");
    busy = 1'b0;
    rd(2'd2, 32'h0, "R9 follows level");

    // R10: other addresses
    wr(2'd1, 32'h0200);
    wr(2'd0, 32'h0000_FFFF);
    rd(2'd0, 32'h0, "R10 status write ignored");
    wr(2'd2, 32'hFFFF_FFFF);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, 32'h0, "R10 unused address");
    rd(2'd1, 32'h0200, "R10 mask untouched");

    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule